// File: doc/BRIEF.md
# Thread-Exclusive Atomic Admission Gate

This block sits in front of a memory sequencer that several hardware threads share. Each cycle it sees one candidate request, made of a thread id, a request kind and an address. It decides whether that request may enter.

While one thread is part-way through read-modify-write (RMW) sequences, the gate holds off every other thread. It does this by recording which thread owns the atomic window. It also counts how many RMW reads from that thread still lack their matching RMW write. The window closes only when that count returns to zero.

A request that is admitted is forwarded in the same cycle, tagged with the thread id that issued it. An external write-buffer stall input refuses all requests before the atomic check is applied. Misuse of the read/write pairing sets a sticky protocol error flag and leaves the lock state as it was.

Top module: `atomic_gate`

## Requirements
- R1: After reset, no thread owns the window, the outstanding count is zero, `proto_err` is 0, and `req_ready` is 1 whenever `wb_stall` is 0. `req_ready` does not depend on `req_valid`.
- R2: While `wb_stall` is 1, `req_ready` is 0 for every thread and kind, and the lock state is unchanged.
- R3: While a thread owns the window, a request from any other thread gets `req_ready` = 0 whatever its kind, and changes neither the owner nor the count.
- R4: An accepted RMW read (`req_kind` = 2) while no thread owns the window makes the requesting thread the owner, with a count of one.
- R5: An accepted RMW read from the owner leaves the owner in place and adds one to the count.
- R6: An accepted RMW write (`req_kind` = 3) from the owner subtracts one from the count. When the count reaches zero, the window is released and all threads are admitted again.
- R7: Loads (`req_kind` = 0) and stores (`req_kind` = 1) from the owner, and any non-atomic request while the window is free, are admitted without changing the lock state.
- R8: A request is accepted when `req_valid` and `req_ready` are both 1. In that cycle `fwd_valid` is 1 and `fwd_tid`, `fwd_kind` and `fwd_addr` equal the request's thread id, kind and address. Otherwise `fwd_valid` is 0.
- R9: An accepted RMW write while no thread owns the window sets `proto_err` from the next cycle on and does not change the lock state.
- R10: An accepted RMW read from the owner when the count is at its maximum (2^CNT_W - 1) sets `proto_err`. The count stays at the maximum, and the same number of writes is still needed to release the window.
- R11: Once set, `proto_err` stays at 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A candidate request is present |
| req_tid | input | TID_W | Issuing thread id |
| req_kind | input | 2 | 0 load, 1 store, 2 RMW read, 3 RMW write |
| req_addr | input | ADDR_W | Request address |
| wb_stall | input | 1 | Write-buffer flush in progress; refuse everything |
| req_ready | output | 1 | The request may be accepted this cycle |
| fwd_valid | output | 1 | Request forwarded toward the cache |
| fwd_tid | output | TID_W | Thread id tag on the forwarded request |
| fwd_kind | output | 2 | Kind of the forwarded request |
| fwd_addr | output | ADDR_W | Address of the forwarded request |
| proto_err | output | 1 | Sticky pairing-violation flag |

## Verification
The bench nests RMW reads from one thread. It then checks that other threads stay blocked until the last matching write, and not one write earlier. A design that freed the window on the first write, or on a single lock bit, would let a foreign thread through too early.

It pushes the count to its ceiling and issues one more read. A wrapping counter would free the window after too few writes, and the bench catches that through the timing of `req_ready` for other threads. The bench also issues an unpaired write while the window is free, and stalls with the owner's write pending. Both must leave the lock untouched, and the first must raise the sticky error.

// File: rtl/atomic_gate_pkg.sv
package atomic_gate_pkg;

    typedef enum logic [1:0] {
        K_LOAD   = 2'd0,
        K_STORE  = 2'd1,
        K_RMW_RD = 2'd2,
        K_RMW_WR = 2'd3
    } req_kind_e;

    typedef enum logic [2:0] {
        F_NONE        = 3'd0,
        F_WR_UNOWNED  = 3'd1,
        F_WR_EMPTY    = 3'd2,
        F_CLAIM_DIRTY = 3'd3,
        F_OVERFLOW    = 3'd4
    } fault_e;

    function automatic logic is_rmw(input req_kind_e k);
        return (k == K_RMW_RD) || (k == K_RMW_WR);
    endfunction

endpackage

// File: rtl/gate_admit.sv
module gate_admit
    import atomic_gate_pkg::*;
#(
    parameter int TID_W = 2,
    parameter int CNT_W = 4
) (
    input  logic             busy,
    input  logic [TID_W-1:0] owner,
    input  logic [CNT_W-1:0] depth,
    input  logic             valid,
    input  logic [TID_W-1:0] tid,
    input  req_kind_e        kind,
    input  logic             stall,
    output logic             ready,
    output logic             upd,
    output logic             nxt_busy,
    output logic [TID_W-1:0] nxt_owner,
    output logic [CNT_W-1:0] nxt_depth,
    output fault_e           fault
);
    localparam logic [CNT_W-1:0] DEPTH_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] DEPTH_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    logic foreign;
    logic fire;

    assign foreign = busy && (tid != owner);
    assign ready   = !stall && !foreign;
    assign fire    = valid && ready;

    always_comb begin
        upd       = 1'b0;
        nxt_busy  = busy;
        nxt_owner = owner;
        nxt_depth = depth;
        fault     = F_NONE;
        if (fire && is_rmw(kind)) begin
            if (kind == K_RMW_RD) begin
                if (!busy) begin
                    if (depth != '0) begin
                        fault = F_CLAIM_DIRTY;
                    end else begin
                        upd       = 1'b1;
                        nxt_busy  = 1'b1;
                        nxt_owner = tid;
                        nxt_depth = DEPTH_ONE;
                    end
                end else if (depth == DEPTH_MAX) begin
                    fault = F_OVERFLOW;
                end else begin
                    upd       = 1'b1;
                    nxt_depth = depth + DEPTH_ONE;
                end
            end else begin
                if (!busy) begin
                    fault = F_WR_UNOWNED;
                end else if (depth == '0) begin
                    fault = F_WR_EMPTY;
                end else begin
                    upd       = 1'b1;
                    nxt_depth = depth - DEPTH_ONE;
                    nxt_busy  = (depth != DEPTH_ONE);
                    if (depth == DEPTH_ONE) begin
                        nxt_owner = '0;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/gate_lock_reg.sv
module gate_lock_reg
    import atomic_gate_pkg::*;
#(
    parameter int TID_W = 2,
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             upd,
    input  logic             nxt_busy,
    input  logic [TID_W-1:0] nxt_owner,
    input  logic [CNT_W-1:0] nxt_depth,
    input  fault_e           fault,
    output logic             busy_q,
    output logic [TID_W-1:0] owner_q,
    output logic [CNT_W-1:0] depth_q,
    output logic             err_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q  <= 1'b0;
            owner_q <= '0;
            depth_q <= '0;
            err_q   <= 1'b0;
        end else begin
            if (upd) begin
                busy_q  <= nxt_busy;
                owner_q <= nxt_owner;
                depth_q <= nxt_depth;
            end
            if (fault != F_NONE) begin
                err_q <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/gate_fwd.sv
module gate_fwd
    import atomic_gate_pkg::*;
#(
    parameter int TID_W  = 2,
    parameter int ADDR_W = 32
) (
    input  logic              valid,
    input  logic              ready,
    input  logic [TID_W-1:0]  tid,
    input  req_kind_e         kind,
    input  logic [ADDR_W-1:0] addr,
    output logic              out_valid,
    output logic [TID_W-1:0]  out_tid,
    output logic [1:0]        out_kind,
    output logic [ADDR_W-1:0] out_addr
);
    always_comb begin
        out_valid = valid && ready;
        out_tid   = out_valid ? tid  : '0;
        out_kind  = out_valid ? kind : 2'd0;
        out_addr  = out_valid ? addr : '0;
    end
endmodule

// File: rtl/atomic_gate.sv
module atomic_gate
    import atomic_gate_pkg::*;
#(
    parameter int TID_W  = 2,
    parameter int CNT_W  = 4,
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [TID_W-1:0]  req_tid,
    input  logic [1:0]        req_kind,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              wb_stall,
    output logic              req_ready,
    output logic              fwd_valid,
    output logic [TID_W-1:0]  fwd_tid,
    output logic [1:0]        fwd_kind,
    output logic [ADDR_W-1:0] fwd_addr,
    output logic              proto_err
);
    req_kind_e        kind_e;
    logic             busy_q;
    logic [TID_W-1:0] owner_q;
    logic [CNT_W-1:0] depth_q;
    logic             upd;
    logic             nxt_busy;
    logic [TID_W-1:0] nxt_owner;
    logic [CNT_W-1:0] nxt_depth;
    fault_e           fault;

    assign kind_e = req_kind_e'(req_kind);

    gate_admit #(.TID_W(TID_W), .CNT_W(CNT_W)) u_admit (
        .busy      (busy_q),
        .owner     (owner_q),
        .depth     (depth_q),
        .valid     (req_valid),
        .tid       (req_tid),
        .kind      (kind_e),
        .stall     (wb_stall),
        .ready     (req_ready),
        .upd       (upd),
        .nxt_busy  (nxt_busy),
        .nxt_owner (nxt_owner),
        .nxt_depth (nxt_depth),
        .fault     (fault)
    );

    gate_lock_reg #(.TID_W(TID_W), .CNT_W(CNT_W)) u_lock (
        .clk       (clk),
        .rst       (rst),
        .upd       (upd),
        .nxt_busy  (nxt_busy),
        .nxt_owner (nxt_owner),
        .nxt_depth (nxt_depth),
        .fault     (fault),
        .busy_q    (busy_q),
        .owner_q   (owner_q),
        .depth_q   (depth_q),
        .err_q     (proto_err)
    );

    gate_fwd #(.TID_W(TID_W), .ADDR_W(ADDR_W)) u_fwd (
        .valid     (req_valid),
        .ready     (req_ready),
        .tid       (req_tid),
        .kind      (kind_e),
        .addr      (req_addr),
        .out_valid (fwd_valid),
        .out_tid   (fwd_tid),
        .out_kind  (fwd_kind),
        .out_addr  (fwd_addr)
    );
endmodule

// File: rtl/atomic_gate_chk.sv
module atomic_gate_chk #(
    parameter int TID_W = 2,
    parameter int CNT_W = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             req_valid,
    input logic [TID_W-1:0] req_tid,
    input logic [1:0]       req_kind,
    input logic             wb_stall,
    input logic             req_ready,
    input logic             proto_err,
    input logic             busy_q,
    input logic [TID_W-1:0] owner_q,
    input logic [CNT_W-1:0] depth_q
);
    localparam logic [CNT_W-1:0] DEPTH_MAX = {CNT_W{1'b1}};

    logic acc;
    assign acc = req_valid && req_ready;

    // R1: a free window never carries an outstanding count
    a_r1_free_empty: assert property (@(posedge clk) disable iff (rst)
        !busy_q |-> depth_q == '0);

    // R2: a stalled request leaves the lock untouched
    a_r2_stall_hold: assert property (@(posedge clk) disable iff (rst)
        (req_valid && wb_stall) |=> ($stable(busy_q) && $stable(owner_q) && $stable(depth_q)));

    // R3: a foreign request cannot move the lock
    a_r3_foreign_hold: assert property (@(posedge clk) disable iff (rst)
        (req_valid && busy_q && req_tid != owner_q) |=> ($stable(owner_q) && $stable(depth_q)));

    // R4: claiming an idle window
    a_r4_claim: assert property (@(posedge clk) disable iff (rst)
        (acc && req_kind == 2'd2 && !busy_q) |=> (busy_q && owner_q == $past(req_tid) && depth_q == 1));

    // R6: last write releases the window
    a_r6_release: assert property (@(posedge clk) disable iff (rst)
        (acc && req_kind == 2'd3 && busy_q && depth_q == 1) |=> (!busy_q && depth_q == '0));

    // R10: no wrap of the count
    a_r10_no_wrap: assert property (@(posedge clk) disable iff (rst)
        (acc && req_kind == 2'd2 && busy_q && depth_q == DEPTH_MAX) |=> (depth_q == DEPTH_MAX && proto_err));

    // R11: error flag is sticky
    a_r11_sticky: assert property (@(posedge clk) disable iff (rst)
        proto_err |=> proto_err);
endmodule

bind atomic_gate atomic_gate_chk #(.TID_W(TID_W), .CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_tid   (req_tid),
    .req_kind  (req_kind),
    .wb_stall  (wb_stall),
    .req_ready (req_ready),
    .proto_err (proto_err),
    .busy_q    (busy_q),
    .owner_q   (owner_q),
    .depth_q   (depth_q)
);

// File: tb/atomic_gate_test.sv
`timescale 1ns/100ps
module atomic_gate_test;
    localparam int TID_W  = 2;
    localparam int CNT_W  = 4;
    localparam int ADDR_W = 32;
    localparam int NTHR   = 1 << TID_W;
    localparam int DMAX   = (1 << CNT_W) - 1;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              req_valid = 1'b0;
    logic [TID_W-1:0]  req_tid = '0;
    logic [1:0]        req_kind = 2'd0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic              wb_stall = 1'b0;
    logic              req_ready;
    logic              fwd_valid;
    logic [TID_W-1:0]  fwd_tid;
    logic [1:0]        fwd_kind;
    logic [ADDR_W-1:0] fwd_addr;
    logic              proto_err;

    always #2.5 clk = ~clk;

    atomic_gate #(.TID_W(TID_W), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_tid(req_tid),
        .req_kind(req_kind), .req_addr(req_addr), .wb_stall(wb_stall),
        .req_ready(req_ready), .fwd_valid(fwd_valid), .fwd_tid(fwd_tid),
        .fwd_kind(fwd_kind), .fwd_addr(fwd_addr), .proto_err(proto_err)
    );

    int total = 0;
    int bad = 0;
    bit done = 1'b0;
    int m_busy = 0, m_owner = 0, m_depth = 0, m_err = 0;
    int addr_ctr = 32'h1000;

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s act=%0d exp=%0d", tag, what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; req_valid = 1'b0; wb_stall = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        m_busy = 0; m_owner = 0; m_depth = 0; m_err = 0;
    endtask

    task automatic step(input bit v, input int tid, input int kind,
                        input bit stall, input string tag);
        bit exp_ready, exp_fv;
        longint act_tag, exp_tag;
        @(negedge clk);
        addr_ctr = addr_ctr + 4;
        req_valid = v; req_tid = tid[TID_W-1:0]; req_kind = kind[1:0];
        req_addr = addr_ctr; wb_stall = stall;
        #1;
        exp_ready = !stall && !(m_busy != 0 && tid != m_owner);
        exp_fv    = v && exp_ready;
        check(req_ready == exp_ready, tag, "ready", req_ready, exp_ready);
        check(fwd_valid == exp_fv, tag, "fwd_valid", fwd_valid, exp_fv);
        check(proto_err == (m_err != 0), tag, "proto_err", proto_err, m_err);
        if (exp_fv) begin
            act_tag = {fwd_tid, fwd_kind, fwd_addr};
            exp_tag = {tid[TID_W-1:0], kind[1:0], addr_ctr[ADDR_W-1:0]};
            check(act_tag == exp_tag, tag, "fwd_tag", act_tag, exp_tag);
        end
        @(posedge clk);
        if (exp_fv) begin
            if (kind == 2) begin
                if (m_busy == 0) begin
                    m_busy = 1; m_owner = tid; m_depth = 1;
                end else if (m_depth == DMAX) begin
                    m_err = 1;
                end else begin
                    m_depth++;
                end
            end else if (kind == 3) begin
                if (m_busy == 0) begin
                    m_err = 1;
                end else begin
                    m_depth--;
                    if (m_depth == 0) m_busy = 0;
                end
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++;
            $display("FAIL R1 watchdog act=timeout exp=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        do_reset();
        step(0, 0, 0, 0, "R1");
        step(0, 3, 2, 0, "R1");
        for (int t = 0; t < NTHR; t++) step(1, t, t % 2, 0, "R7");
        step(1, 1, 2, 0, "R4");
        step(1, 0, 0, 0, "R3");
        step(1, 2, 2, 0, "R3");
        step(1, 3, 3, 0, "R3");
        step(1, 1, 1, 0, "R7");
        step(1, 1, 0, 0, "R7");
        step(1, 2, 1, 0, "R7");
        step(1, 1, 2, 0, "R5");
        step(1, 1, 3, 1, "R2");
        step(1, 0, 0, 1, "R2");
        step(1, 1, 3, 0, "R6");
        step(1, 0, 0, 0, "R6");
        step(1, 1, 3, 0, "R6");
        step(1, 0, 0, 0, "R6");
        step(1, 2, 1, 0, "R8");
        // push the count to its ceiling and past it
        for (int i = 0; i < DMAX; i++) step(1, 3, 2, 0, "R5");
        step(1, 3, 2, 0, "R10");
        step(1, 3, 0, 0, "R10");
        for (int i = 0; i < DMAX - 1; i++) step(1, 3, 3, 0, "R10");
        step(1, 0, 1, 0, "R10");
        step(1, 3, 3, 0, "R10");
        step(1, 0, 1, 0, "R10");
        // reset clears the flag
        do_reset();
        step(1, 2, 0, 0, "R1");
        step(1, 0, 3, 0, "R9");
        step(1, 1, 0, 0, "R9");
        step(1, 2, 2, 0, "R11");
        step(1, 2, 3, 0, "R11");
        step(0, 0, 0, 0, "R11");
        // mixed traffic, compared against the model every cycle
        do_reset();
        for (int i = 0; i < 400; i++) begin
            int t, k;
            t = $urandom_range(0, NTHR - 1);
            k = $urandom_range(0, 3);
            if (m_busy != 0 && $urandom_range(0, 1) == 1) t = m_owner;
            step($urandom_range(0, 7) != 0, t, k, $urandom_range(0, 9) == 0, "R8");
        end
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule